// File: doc/BRIEF.md
# Dual-Rate Seconds Timebase

This block turns a 50 MHz system clock into the two timebases that drive a digital alarm clock's time counters. The clock-time timebase is a 1 Hz square wave. It switches to a setting rate 500 times faster while clock-setting mode is selected and the shared adjust button is held. The alarm-setting timebase runs at that same fast rate, but only while alarm-setting mode is selected and the button is held. At all other times it stays frozen, keeping both its output level and its internal count.

Each timebase has two counters in cascade. A first-stage prescaler wraps after a terminal count. For the clock timebase that count is chosen at run time from the mode level and the button. A second stage counts prescaler wraps and toggles the square wave when it reaches its own count.

Alongside each square wave, the block gives a one-cycle strobe on every rising edge. Downstream counters can then stay in the system clock domain instead of using the wave as a clock. All pins are plain levels; the block has no streaming data path.

Top module: `dual_tick_gen`

## Requirements
- R1: An active-low asynchronous reset clears both counter stages of both timebases at once and drives all four outputs low, with no clock edge needed.
- R2: In normal mode the clock wave toggles once every SLOW_DIV*TOGGLE_DIV clock cycles. After reset is released, the first rise comes on exactly that clock edge. With the defaults this gives 1 Hz.
- R3: Fast mode applies only when clk_set_mode is 1 and adj_btn_n is 0. The clock wave then toggles every FAST_DIV*TOGGLE_DIV cycles. Every other combination of these two inputs gives the normal rate of R2.
- R4: The alarm timebase advances only while alm_set_mode is 1 and adj_btn_n is 0. In every other condition its counters and wave level are held and its strobe stays 0. When it is enabled again, it continues from the held phase.
- R5: While enabled, the alarm wave toggles every FAST_DIV*TOGGLE_DIV cycles.
- R6: Each strobe (clk_tick, alm_tick) is high for exactly one cycle: the cycle in which its wave goes from 0 to 1. It never pulses on a falling edge.
- R7: If the first-stage terminal count drops below the current prescaler value, the prescaler wraps to zero on the next edge. That wrap counts as one prescaler wrap, and the count never runs past the limit.
- R8: The clock timebase rate does not depend on alm_set_mode. Alarm setting with the button held leaves the clock wave at the normal rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_set_mode | input | 1 | Clock-setting mode level |
| alm_set_mode | input | 1 | Alarm-setting mode level |
| adj_btn_n | input | 1 | Shared adjust button, active low (0 = held) |
| clk_wave | output | 1 | Clock-time square wave |
| clk_tick | output | 1 | One-cycle strobe on each rise of clk_wave |
| alm_wave | output | 1 | Alarm-setting square wave |
| alm_tick | output | 1 | One-cycle strobe on each rise of alm_wave |

## Verification
All outputs are registered. A change of mode or button applied just after one rising edge takes effect on the next rising edge, and the resulting wave and strobe values appear on that same edge. The bench drives inputs and samples outputs only on falling edges, and it measures every interval as a count of falling edges between strobes. The first rise after reset is therefore due on falling edge SLOW_DIV*TOGGLE_DIV. A terminal-count shrink from a prescaler value of 7 gives a rise five edges later, and an alarm timebase frozen after four enabled edges rises two edges after it is re-enabled. The bench shrinks the divide parameters so these exact counts can be checked in a short run.

// File: rtl/tick_pkg.sv
package tick_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] term,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;

  // ">=" so that a terminal count lowered below the running value wraps at once
  assign wrap = en && (cnt_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  AST_PRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R4
  AST_PRE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q > term) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/tick_toggle.sv
module tick_toggle #(
  parameter int TOGGLE_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic wave,
  output logic tick
);
  localparam int TW = tick_pkg::cnt_width(TOGGLE_DIV);
  localparam logic [TW-1:0] LAST = TW'(TOGGLE_DIV - 1);

  logic [TW-1:0] post_q;
  logic          wave_q;
  logic          tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= '0;
      wave_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (step) begin
        if (post_q == LAST) begin
          post_q <= '0;
          wave_q <= ~wave_q;
          tick_q <= ~wave_q;
        end else begin
          post_q <= post_q + 1'b1;
        end
      end
    end
  end

  assign wave = wave_q;
  assign tick = tick_q;

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R6
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (wave_q && !$past(wave_q))); // R6
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(wave_q)); // R4
  AST_POST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    post_q <= LAST); // R2
endmodule

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int SLOW_DIV   = 25000,
  parameter int FAST_DIV   = 50,
  parameter int TOGGLE_DIV = 1000,
  parameter bit SELECTABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic wave,
  output logic tick
);
  import tick_pkg::*;

  localparam int TOP_DIV = SELECTABLE ? SLOW_DIV : FAST_DIV;
  localparam int CW      = cnt_width(TOP_DIV);
  localparam logic [CW-1:0] SLOW_TERM = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] FAST_TERM = CW'(FAST_DIV - 1);

  logic [CW-1:0] term;
  logic          wrap;
  rate_e         rate;

  generate
    if (SELECTABLE) begin : g_sel
      assign rate = fast ? RATE_FAST : RATE_SLOW;
      assign term = (rate == RATE_FAST) ? FAST_TERM : SLOW_TERM;
    end else begin : g_fixed
      assign rate = RATE_FAST;
      assign term = FAST_TERM;
    end
  endgenerate

  tick_prescale #(.CW(CW)) i_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .term (term),
    .wrap (wrap)
  );

  tick_toggle #(.TOGGLE_DIV(TOGGLE_DIV)) i_tog (
    .clk  (clk),
    .rst_n(rst_n),
    .step (wrap),
    .wave (wave),
    .tick (tick)
  );
endmodule

// File: rtl/dual_tick_gen.sv
module dual_tick_gen #(
  parameter int SLOW_DIV   = 25000,
  parameter int FAST_DIV   = 50,
  parameter int TOGGLE_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_set_mode,
  input  logic alm_set_mode,
  input  logic adj_btn_n,
  output logic clk_wave,
  output logic clk_tick,
  output logic alm_wave,
  output logic alm_tick
);
  logic btn_held;
  logic clk_fast;
  logic alm_run;

  assign btn_held = ~adj_btn_n;
  assign clk_fast = clk_set_mode & btn_held;
  assign alm_run  = alm_set_mode & btn_held;

  tick_channel #(
    .SLOW_DIV  (SLOW_DIV),
    .FAST_DIV  (FAST_DIV),
    .TOGGLE_DIV(TOGGLE_DIV),
    .SELECTABLE(1'b1)
  ) i_clk_ch (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (1'b1),
    .fast (clk_fast),
    .wave (clk_wave),
    .tick (clk_tick)
  );

  tick_channel #(
    .SLOW_DIV  (SLOW_DIV),
    .FAST_DIV  (FAST_DIV),
    .TOGGLE_DIV(TOGGLE_DIV),
    .SELECTABLE(1'b0)
  ) i_alm_ch (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (alm_run),
    .fast (1'b1),
    .wave (alm_wave),
    .tick (alm_tick)
  );

  AST_ALM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(alm_set_mode && !adj_btn_n) |-> !alm_tick); // R4
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !(clk_wave || clk_tick || alm_wave || alm_tick)); // R1
endmodule

// File: tb/test_dual_tick_gen.sv
module test_dual_tick_gen;
  localparam int SD = 10;
  localparam int FD = 2;
  localparam int TD = 3;
  localparam int SLOW_PER = 2 * SD * TD;
  localparam int FAST_PER = 2 * FD * TD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_set_mode = 1'b0;
  logic alm_set_mode = 1'b0;
  logic adj_btn_n = 1'b1;
  logic clk_wave, clk_tick, alm_wave, alm_tick;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  dual_tick_gen #(.SLOW_DIV(SD), .FAST_DIV(FD), .TOGGLE_DIV(TD)) i_dual_tick_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_set_mode(clk_set_mode),
    .alm_set_mode(alm_set_mode),
    .adj_btn_n   (adj_btn_n),
    .clk_wave    (clk_wave),
    .clk_tick    (clk_tick),
    .alm_wave    (alm_wave),
    .alm_tick    (alm_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic cm, input logic am, input logic bn);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({clk_wave, clk_tick, alm_wave, alm_tick} == 4'b0, "R1 reset outputs",
          int'({clk_wave, clk_tick, alm_wave, alm_tick}), 0);
    clk_set_mode = cm;
    alm_set_mode = am;
    adj_btn_n    = bn;
    rst_n = 1'b1;
  endtask

  task automatic wait_tick(input int which, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((which == 0) ? clk_tick : alm_tick) && n < limit);
  endtask

  task automatic period(input int which, output int p);
    int dummy;
    wait_tick(which, 400, dummy);
    wait_tick(which, 400, p);
  endtask

  task automatic t_first_rise();
    int n;
    do_reset(1'b0, 1'b0, 1'b1);
    wait_tick(0, 200, n);
    check(n == SD * TD, "R2 first rise cycle", n, SD * TD);
    check(clk_wave == 1'b1, "R6 wave high with strobe", int'(clk_wave), 1);
    @(negedge clk);
    check(clk_tick == 1'b0 && clk_wave == 1'b1, "R6 strobe single cycle", int'(clk_tick), 0);
  endtask

  task automatic t_rates();
    int p;
    int bad = 0;
    do_reset(1'b0, 1'b0, 1'b1);
    period(0, p);
    check(p == SLOW_PER, "R2 normal period", p, SLOW_PER);
    // no strobe while wave falls
    for (int i = 0; i < SLOW_PER; i++) begin
      @(negedge clk);
      if (clk_tick && !clk_wave) bad++;
    end
    check(bad == 0, "R6 no strobe on fall", bad, 0);
    clk_set_mode = 1'b1; adj_btn_n = 1'b0;
    period(0, p);
    check(p == FAST_PER, "R3 fast period", p, FAST_PER);
    check(SLOW_PER / p == SD / FD, "R3 rate ratio", SLOW_PER / p, SD / FD);
    clk_set_mode = 1'b1; adj_btn_n = 1'b1;
    period(0, p);
    check(p == SLOW_PER, "R3 mode without button", p, SLOW_PER);
    clk_set_mode = 1'b0; adj_btn_n = 1'b0;
    period(0, p);
    check(p == SLOW_PER, "R3 button without mode", p, SLOW_PER);
  endtask

  task automatic t_alarm();
    int p;
    int moved = 0;
    do_reset(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (alm_wave || alm_tick) moved++;
    end
    check(moved == 0, "R4 alarm idle without mode", moved, 0);
    alm_set_mode = 1'b1; adj_btn_n = 1'b1;
    moved = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (alm_wave || alm_tick) moved++;
    end
    check(moved == 0, "R4 alarm idle without button", moved, 0);
    adj_btn_n = 1'b0;
    period(1, p);
    check(p == FAST_PER, "R5 alarm period", p, FAST_PER);
    period(0, p);
    check(p == SLOW_PER, "R8 clock rate during alarm set", p, SLOW_PER);
  endtask

  task automatic t_freeze_phase();
    int n;
    int moved = 0;
    logic held;
    do_reset(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    adj_btn_n = 1'b1;
    held = alm_wave;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (alm_wave != held || alm_tick) moved++;
    end
    check(moved == 0, "R4 frozen level", moved, 0);
    adj_btn_n = 1'b0;
    wait_tick(1, 100, n);
    check(n == 2, "R4 phase resumes", n, 2);
  endtask

  task automatic t_shrink();
    int n;
    do_reset(1'b0, 1'b0, 1'b1);
    repeat (7) @(negedge clk);
    clk_set_mode = 1'b1; adj_btn_n = 1'b0;
    wait_tick(0, 200, n);
    check(n == 5, "R7 limit shrink wrap", n, 5);
  endtask

  task automatic t_async_reset();
    int n;
    do_reset(1'b0, 1'b0, 1'b1);
    wait_tick(0, 200, n);
    #3 rst_n = 1'b0;
    #1;
    check(clk_wave == 1'b0 && clk_tick == 1'b0, "R1 async clear", int'(clk_wave), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    t_first_rise();
    t_rates();
    t_alarm();
    t_freeze_phase();
    t_shrink();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule